// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Controller

This block collects per-vector interrupt requests, decides which one the processor may take next, and keeps track of nested handlers. Each vector has a request bit, an enable bit and a one-bit level selection. Cleared, the selection places the vector at the low level. Set, it places the vector at the highest level when the vector is one of the designated top-capable vectors, and at the high level otherwise. When several sources must share a vector, their requests are OR-ed outside this block before they reach its request input.

A winning vector is offered to the processor on an interrupt line together with its address. The offer is held unchanged until the processor pulses acknowledge. The acknowledge records the vector's level as in service. A return strobe from the processor retires the most recent level. A request is only offered when its level is strictly above the level currently in service, so nesting is limited to three handlers: low, then high, then highest.

Top module: `vecirq_ctrl`

## Requirements
- R1: After reset, irq_o is 0 and cur_lvl_o is 0 (nothing in service).
- R2: A vector whose enable bit is 0 never causes irq_o to rise, even while its request is 1.
- R3: The level encoding on cur_lvl_o is 0 none, 1 low, 2 high, 3 highest. A vector with lvl_sel_i 0 is low. A vector with lvl_sel_i 1 is highest if its bit in TOP_MASK is set (vectors 0 and 1 by default), and high otherwise.
- R4: The offered address is VEC_BASE + VEC_STEP × index, which is 03h, 0Bh, 13h, … 3Bh for indices 0 to 7 by default.
- R5: Among enabled, pending vectors, the one with the greatest level is offered.
- R6: Among offered candidates of equal level, the lowest vector index (smallest address) wins.
- R7: A request whose level is equal to or lower than cur_lvl_o is not offered. It becomes eligible once returns lower cur_lvl_o beneath it.
- R8: While irq_o is 1 and ack_i is 0, irq_o stays 1 and vec_addr_o stays unchanged, even if the request is withdrawn.
- R9: ack_i while irq_o is 1 makes cur_lvl_o equal to the offered level and clears irq_o, both on the next cycle.
- R10: A ret_i pulse lowers cur_lvl_o to the level in service before the most recent one. A ret_i pulse with nothing in service has no effect.
- R11: Three nested levels can be in service at once and are retired in reverse order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_VEC | Per-vector pending request |
| en_i | input | NUM_VEC | Per-vector enable |
| lvl_sel_i | input | NUM_VEC | Per-vector level raise (0 = low) |
| ack_i | input | 1 | Processor takes the offered vector |
| ret_i | input | 1 | Processor leaves the current handler |
| irq_o | output | 1 | Interrupt offered |
| vec_addr_o | output | ADDR_W | Address of the offered vector |
| cur_lvl_o | output | 2 | Highest level in service |

## Verification
The bench builds the block with its default parameters: eight vectors, the first two able to reach the highest level, and addresses starting at 03h in steps of 8. With these values every address can be exercised, and the contrast between a top-capable vector and an ordinary one under the same level selection can be checked. A full low, high and highest nesting chain can also be built up and then unwound in reverse order.

// File: rtl/vic_pkg.sv
package vic_pkg;
   typedef enum logic [1:0] {
      LVL_NONE = 2'd0,
      LVL_LOW  = 2'd1,
      LVL_HIGH = 2'd2,
      LVL_TOP  = 2'd3
   } vic_lvl_e;
endpackage

// File: rtl/vic_level_map.sv
module vic_level_map
   import vic_pkg::*;
#(
   parameter int          NUM_VEC  = 8,
   parameter logic [31:0] TOP_MASK = 32'h3
) (
   input  logic [NUM_VEC-1:0] req,
   input  logic [NUM_VEC-1:0] en,
   input  logic [NUM_VEC-1:0] sel,
   output vic_lvl_e           lvl [NUM_VEC]
);
   for (genvar i = 0; i < NUM_VEC; i++) begin : g_vec
      if (TOP_MASK[i]) begin : g_top
         // raise selects the highest level
         assign lvl[i] = !(req[i] && en[i]) ? LVL_NONE :
                         (sel[i] ? LVL_TOP : LVL_LOW);
      end else begin : g_plain
         // raise selects the high level only
         assign lvl[i] = !(req[i] && en[i]) ? LVL_NONE :
                         (sel[i] ? LVL_HIGH : LVL_LOW);
      end
   end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
   import vic_pkg::*;
#(
   parameter int NUM_VEC = 8,
   localparam int IDX_W  = $clog2(NUM_VEC)
) (
   input  vic_lvl_e         lvl [NUM_VEC],
   output vic_lvl_e         win_lvl,
   output logic [IDX_W-1:0] win_idx
);
   always_comb begin
      win_lvl = LVL_NONE;
      win_idx = '0;
      // scan downward so that ties settle on the lowest index
      for (int i = NUM_VEC - 1; i >= 0; i--) begin
         if (lvl[i] != LVL_NONE && lvl[i] >= win_lvl) begin
            win_lvl = lvl[i];
            win_idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/vic_nest_track.sv
module vic_nest_track
   import vic_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     push,
   input  vic_lvl_e push_lvl,
   input  logic     pop,
   output vic_lvl_e cur_lvl
);
   logic [3:1] svc_q;
   logic [3:1] svc_d;
   logic [3:1] top_bit;
   logic [3:1] new_bit;

   always_comb begin
      if (svc_q[3])      cur_lvl = LVL_TOP;
      else if (svc_q[2]) cur_lvl = LVL_HIGH;
      else if (svc_q[1]) cur_lvl = LVL_LOW;
      else               cur_lvl = LVL_NONE;
   end

   always_comb begin
      top_bit = '0;
      new_bit = '0;
      if (cur_lvl != LVL_NONE) top_bit[cur_lvl] = 1'b1;
      if (push_lvl != LVL_NONE) new_bit[push_lvl] = 1'b1;
      svc_d = svc_q;
      if (pop)  svc_d = svc_d & ~top_bit;
      if (push) svc_d = svc_d | new_bit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) svc_q <= '0;
      else        svc_q <= svc_d;
   end
endmodule

// File: rtl/vecirq_ctrl.sv
module vecirq_ctrl
   import vic_pkg::*;
#(
   parameter int          NUM_VEC  = 8,
   parameter int          ADDR_W   = 8,
   parameter int          VEC_BASE = 3,
   parameter int          VEC_STEP = 8,
   parameter logic [31:0] TOP_MASK = 32'h3,
   localparam int         IDX_W    = $clog2(NUM_VEC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_VEC-1:0] req_i,
   input  logic [NUM_VEC-1:0] en_i,
   input  logic [NUM_VEC-1:0] lvl_sel_i,
   input  logic               ack_i,
   input  logic               ret_i,
   output logic               irq_o,
   output logic [ADDR_W-1:0]  vec_addr_o,
   output logic [1:0]         cur_lvl_o
);
   if (NUM_VEC < 2 || NUM_VEC > 32) begin : g_bad_count
      $error("vecirq_ctrl: NUM_VEC must lie in 2..32");
   end
   if (VEC_BASE + (NUM_VEC - 1) * VEC_STEP >= (1 << ADDR_W)) begin : g_bad_addr
      $error("vecirq_ctrl: vector addresses exceed ADDR_W");
   end

   vic_lvl_e         cand_lvl [NUM_VEC];
   vic_lvl_e         win_lvl;
   logic [IDX_W-1:0] win_idx;
   vic_lvl_e         cur_lvl;

   logic             offer_valid;
   vic_lvl_e         offer_lvl;
   logic [IDX_W-1:0] offer_idx;
   logic             take;

   vic_level_map #(.NUM_VEC(NUM_VEC), .TOP_MASK(TOP_MASK)) i_map (
      .req (req_i),
      .en  (en_i),
      .sel (lvl_sel_i),
      .lvl (cand_lvl)
   );

   vic_arbiter #(.NUM_VEC(NUM_VEC)) i_arb (
      .lvl     (cand_lvl),
      .win_lvl (win_lvl),
      .win_idx (win_idx)
   );

   assign take = offer_valid && ack_i;

   vic_nest_track i_nest (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (take),
      .push_lvl (offer_lvl),
      .pop      (ret_i),
      .cur_lvl  (cur_lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         offer_valid <= 1'b0;
         offer_lvl   <= LVL_NONE;
         offer_idx   <= '0;
      end else if (offer_valid) begin
         if (ack_i) offer_valid <= 1'b0;
      end else if (win_lvl > cur_lvl) begin
         offer_valid <= 1'b1;
         offer_lvl   <= win_lvl;
         offer_idx   <= win_idx;
      end
   end

   assign irq_o      = offer_valid;
   assign vec_addr_o = ADDR_W'(VEC_BASE) + ADDR_W'(offer_idx) * ADDR_W'(VEC_STEP);
   assign cur_lvl_o  = cur_lvl;
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
   parameter int          NUM_VEC  = 8,
   parameter int          ADDR_W   = 8,
   parameter logic [31:0] TOP_MASK = 32'h3,
   localparam int         IDX_W    = $clog2(NUM_VEC)
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_VEC-1:0] req_i,
   input logic [NUM_VEC-1:0] en_i,
   input logic               ack_i,
   input logic               ret_i,
   input logic               irq_o,
   input logic [ADDR_W-1:0]  vec_addr_o,
   input logic [1:0]         cur_lvl_o,
   input logic [1:0]         offer_lvl,
   input logic [IDX_W-1:0]   offer_idx
);
   // R8
   a_r8_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o && !ack_i |=> irq_o && $stable(vec_addr_o));
   // R9
   a_r9_ack_pushes: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o && ack_i && !ret_i |=> !irq_o && cur_lvl_o > $past(cur_lvl_o));
   // R10
   a_r10_only_ret_lowers: assert property (@(posedge clk) disable iff (!rst_n)
      !ret_i |=> cur_lvl_o >= $past(cur_lvl_o));
   // R2
   a_r2_needs_enabled_req: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(|(req_i & en_i)));
   // R7
   a_r7_above_service: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> offer_lvl > cur_lvl_o);
   // R3
   a_r3_top_capable: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o && offer_lvl == 2'd3 |-> TOP_MASK[offer_idx]);
endmodule

bind vecirq_ctrl vic_checker #(
   .NUM_VEC (NUM_VEC),
   .ADDR_W  (ADDR_W),
   .TOP_MASK(TOP_MASK)
) i_vic_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_i      (req_i),
   .en_i       (en_i),
   .ack_i      (ack_i),
   .ret_i      (ret_i),
   .irq_o      (irq_o),
   .vec_addr_o (vec_addr_o),
   .cur_lvl_o  (cur_lvl_o),
   .offer_lvl  (offer_lvl),
   .offer_idx  (offer_idx)
);

// File: tb/test_vecirq_ctrl.sv
module test_vecirq_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NV-1:0] req = '0;
   logic [NV-1:0] en = '0;
   logic [NV-1:0] sel = '0;
   logic          ack = 1'b0;
   logic          ret = 1'b0;
   logic          irq;
   logic [7:0]    addr;
   logic [1:0]    lvl;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   vecirq_ctrl i_vecirq_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (req),
      .en_i       (en),
      .lvl_sel_i  (sel),
      .ack_i      (ack),
      .ret_i      (ret),
      .irq_o      (irq),
      .vec_addr_o (addr),
      .cur_lvl_o  (lvl)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n = 1);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic do_reset();
      req = '0; en = '0; sel = '0; ack = 1'b0; ret = 1'b0;
      rst_n = 1'b0;
      tick(2);
      rst_n = 1'b1;
      tick();
   endtask

   task automatic raise(input int v, input bit s);
      req[v] = 1'b1; en[v] = 1'b1; sel[v] = s;
   endtask

   task automatic take_it();
      ack = 1'b1; req = '0;
      tick();
      ack = 1'b0;
   endtask

   task automatic leave();
      ret = 1'b1;
      tick();
      ret = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      check("R1 irq after reset", irq, 0);
      check("R1 level after reset", lvl, 0);
   endtask

   task automatic t_disabled();
      do_reset();
      req[2] = 1'b1; sel[2] = 1'b1;
      tick(3);
      check("R2 disabled vector no irq", irq, 0);
      en[2] = 1'b1;
      tick();
      check("R2 enabling releases irq", irq, 1);
   endtask

   task automatic t_addr();
      do_reset();
      for (int i = 0; i < NV; i++) begin
         raise(i, 1'b0);
         tick();
         check("R4 irq raised", irq, 1);
         check("R4 vector address", addr, 3 + 8 * i);
         take_it();
         check("R9 irq cleared by ack", irq, 0);
         check("R9 low level in service", lvl, 1);
         leave();
         check("R10 return to none", lvl, 0);
         en = '0;
      end
   endtask

   task automatic t_level();
      do_reset();
      raise(0, 1'b1);
      tick(); take_it();
      check("R3 top-capable raised is highest", lvl, 3);
      do_reset();
      raise(5, 1'b1);
      tick(); take_it();
      check("R3 ordinary raised is high", lvl, 2);
      do_reset();
      raise(1, 1'b0);
      tick(); take_it();
      check("R3 top-capable unraised is low", lvl, 1);
   endtask

   task automatic t_prio();
      do_reset();
      raise(1, 1'b0); raise(6, 1'b1);
      tick();
      check("R5 high beats low", addr, 8'h33);
      do_reset();
      raise(6, 1'b1); raise(0, 1'b1);
      tick();
      check("R5 highest beats high", addr, 8'h03);
   endtask

   task automatic t_tie();
      do_reset();
      raise(5, 1'b1); raise(3, 1'b1); raise(7, 1'b1);
      tick();
      check("R6 lowest index on tie", addr, 8'h1B);
      do_reset();
      raise(6, 1'b0); raise(2, 1'b0);
      tick();
      check("R6 lowest index on low tie", addr, 8'h13);
   endtask

   task automatic t_block();
      do_reset();
      raise(4, 1'b1);
      tick(); take_it();
      check("R7 high in service", lvl, 2);
      raise(2, 1'b1); raise(6, 1'b0);
      tick(3);
      check("R7 equal and lower blocked", irq, 0);
      leave();
      tick();
      check("R7 eligible after return", irq, 1);
      check("R7 high pending wins", addr, 8'h13);
   endtask

   task automatic t_hold();
      do_reset();
      raise(5, 1'b0);
      tick();
      req = '0;
      raise(0, 1'b1);
      tick(3);
      check("R8 irq held", irq, 1);
      check("R8 address held", addr, 8'h2B);
      take_it();
      check("R8 held level pushed", lvl, 1);
   endtask

   task automatic t_nest();
      do_reset();
      raise(7, 1'b0);
      tick(); take_it();
      check("R11 first level", lvl, 1);
      raise(4, 1'b1);
      tick();
      check("R11 high nests over low", addr, 8'h23);
      take_it();
      check("R11 second level", lvl, 2);
      raise(1, 1'b1);
      tick();
      check("R11 highest nests over high", addr, 8'h0B);
      take_it();
      check("R11 third level", lvl, 3);
      leave();
      check("R10 pop to high", lvl, 2);
      leave();
      check("R10 pop to low", lvl, 1);
      leave();
      check("R10 pop to none", lvl, 0);
      leave();
      check("R10 return when idle ignored", lvl, 0);
      check("R10 no irq after idle return", irq, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_disabled();
      t_addr();
      t_level();
      t_prio();
      t_tie();
      t_block();
      t_hold();
      t_nest();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule